// File: doc/BRIEF.md
# I/O Decode and Ready Generator

This block is the slave front end of a device on a 16-bit local bus. It compares the upper twelve address bits with a programmable I/O base. It drives an active-low 16-bit select as soon as the address hits, with no strobe needed. It watches the read and write strobes so it can tell when a real I/O cycle starts. It also holds the bus ready line low when the access has to be stretched.

The ready line runs in one of two modes, chosen by `nowait_i`. With `nowait_i` low, every decoded access is held off for a fixed number of clock cycles, set by `WAIT_CYCLES`. At the default of 30 cycles and a 250 MHz clock, the hold is 120 ns. With `nowait_i` high, only accesses to the data port are held off, and only while the FIFO behind it cannot complete the transfer. A read waits while the read FIFO holds fewer than two bytes. A write waits while the write FIFO holds more than two bytes. Ready is released in the cycle after the fill level makes the transfer possible.

AEN and both strobes pass through two-flop synchronizers before the cycle logic uses them. A controller with four states handles the cycle:

- `ST_IDLE` waits for a rising strobe on a decoded address.
- `ST_FIXED` counts down the fixed window.
- `ST_FIFO` waits on the FIFO fill level.
- `ST_DONE` holds until the strobe is released, so that each access is stretched at most once.

The transitions are as follows:

- IDLE→FIXED: a cycle starts and `nowait_i` is low.
- IDLE→FIFO: a cycle starts, `nowait_i` is high, the access is to the data port, and the FIFO is short.
- IDLE→DONE: any other cycle start.
- FIXED→DONE: the count runs out.
- FIFO→DONE: the FIFO condition clears.
- FIFO→IDLE: the strobe is released early.
- DONE→IDLE: the strobe is released.

Top module: `iodec_ready_top`

## Requirements
- R1: The address hits when `addr_i[15:4]` equals `io_base_i` and `aen_i` is low. On a hit with `bus16_i` high, `cs16_n_o` is low in the same cycle, with no strobe needed. Otherwise `cs16_n_o` is high.
- R2: When `bus16_i` is low, `cs16_n_o` stays high even on an address hit.
- R3: An address hit with no strobe, or a strobe on an address that does not hit, never asserts `rdy_pull_o`.
- R4: A strobe (`ior_n_i` or `iow_n_i` going low) reaches the cycle logic through two synchronizer flops and an edge detector. For an access that waits, `rdy_pull_o` is still 0 two clock cycles after the strobe is first sampled, and is 1 three cycles after.
- R5: With `nowait_i` = 0, every decoded access, read or write, at any offset, holds `rdy_pull_o` at 1 for exactly `WAIT_CYCLES` cycles. The line is then released.
- R6: With `nowait_i` = 1, a read of the data port (address bits 3:1 equal to 3'b100, offset 8 or 9) holds `rdy_pull_o` while `rd_fill_i` < 2. It is released one cycle after `rd_fill_i` reaches 2, or after the strobe ends.
- R7: With `nowait_i` = 1, a write to the data port holds `rdy_pull_o` while `wr_fill_i` > 2. It is released one cycle after `wr_fill_i` falls to 2 or below.
- R8: With `nowait_i` = 1, `rdy_pull_o` is never asserted in three cases: a data read starting with `rd_fill_i` >= 2, a data write starting with `wr_fill_i` <= 2, or an access at any other offset.
- R9: Once the wait has ended, `rdy_pull_o` stays 0 for the rest of the same strobe. A new wait needs the strobe to be released and asserted again.
- R10: A strobe that arrives while `aen_i` is high does not start a cycle, and `rdy_pull_o` stays 0.
- R11: During and right after reset, `rdy_pull_o` is 0 and the controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 16 | Bus address |
| aen_i | input | 1 | Address enable; high marks a DMA cycle, and decode is blocked |
| ior_n_i | input | 1 | Active-low I/O read strobe (asynchronous) |
| iow_n_i | input | 1 | Active-low I/O write strobe (asynchronous) |
| bus16_i | input | 1 | Device is configured for a 16-bit bus |
| io_base_i | input | 12 | I/O base, compared with address bits 15:4 |
| nowait_i | input | 1 | 0: fixed wait on every access; 1: FIFO-driven wait on the data port |
| rd_fill_i | input | 4 | Bytes in the read FIFO |
| wr_fill_i | input | 4 | Bytes in the write FIFO |
| cs16_n_o | output | 1 | Active-low 16-bit select |
| rdy_pull_o | output | 1 | 1 = pull the ready line low (not ready); 0 = release it |

## Verification
The assertions take three things as given about the inputs. First, the read and write strobes are never active together. Second, the address, AEN and base stay stable for as long as a strobe is held. Third, the fill levels change only while a transfer is waiting on them.

The stimulus keeps to these rules in four ways:

- It drives every input on the falling clock edge.
- It asserts only one strobe per access.
- It changes the address and mode only while both strobes are idle.
- It waits several cycles after each release before starting the next access, so the synchronizers settle.

// File: rtl/iodec_pkg.sv
package iodec_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIXED = 2'd1,
        ST_FIFO  = 2'd2,
        ST_DONE  = 2'd3
    } rdy_state_t;
endpackage

// File: rtl/iodec_sync.sv
module iodec_sync #(
    parameter int             WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_bit
            logic meta_q;
            logic stab_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    meta_q <= RST_VAL[gi];
                    stab_q <= RST_VAL[gi];
                end else begin
                    meta_q <= async_i[gi];
                    stab_q <= meta_q;
                end
            end
            assign sync_o[gi] = stab_q;
        end
    endgenerate
endmodule

// File: rtl/iodec_addr_match.sv
module iodec_addr_match #(
    parameter int          ADDR_W   = 16,
    parameter int          BLK_W    = 4,
    parameter logic [BLK_W-1:0] DATA_OFS = 4'h8,
    localparam int         BASE_W   = ADDR_W - BLK_W
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              aen_i,
    input  logic [BASE_W-1:0] base_i,
    input  logic              bus16_i,
    output logic              hit_o,
    output logic              is_data_o,
    output logic              cs16_n_o
);
    localparam logic [BLK_W-1:0] LANE_MASK = {{(BLK_W-1){1'b1}}, 1'b0};

    always_comb begin
        hit_o     = !aen_i && (addr_i[ADDR_W-1:BLK_W] == base_i);
        is_data_o = ((addr_i[BLK_W-1:0] ^ DATA_OFS) & LANE_MASK) == '0;
        cs16_n_o  = !(hit_o && bus16_i);
    end
endmodule

// File: rtl/iodec_ready_fsm.sv
module iodec_ready_fsm
    import iodec_pkg::*;
#(
    parameter int WAIT_CYCLES = 30,
    parameter int FILL_W      = 4,
    parameter int WORD_BYTES  = 2,
    parameter int WR_LIMIT    = 2,
    localparam int CNT_W      = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_s_i,
    input  logic              wr_s_i,
    input  logic              aen_s_i,
    input  logic              hit_i,
    input  logic              is_data_i,
    input  logic              nowait_i,
    input  logic [FILL_W-1:0] rd_fill_i,
    input  logic [FILL_W-1:0] wr_fill_i,
    output logic              rdy_pull_o
);
    localparam logic [CNT_W-1:0]  CNT_LOAD = CNT_W'(WAIT_CYCLES - 1);
    localparam logic [FILL_W-1:0] RD_MIN   = FILL_W'(WORD_BYTES);
    localparam logic [FILL_W-1:0] WR_MAX   = FILL_W'(WR_LIMIT);

    rdy_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             dir_rd_q, dir_rd_d;
    logic             rd_prev_q, wr_prev_q;
    logic             rd_rise, wr_rise, start, strobe_on;
    logic             rd_short, wr_full, need_now, need_held;

    always_comb begin
        rd_rise   = rd_s_i && !rd_prev_q;
        wr_rise   = wr_s_i && !wr_prev_q;
        strobe_on = rd_s_i || wr_s_i;
        start     = (rd_rise || wr_rise) && !aen_s_i && hit_i;
        rd_short  = rd_fill_i < RD_MIN;
        wr_full   = wr_fill_i > WR_MAX;
        need_now  = rd_rise ? rd_short : wr_full;
        need_held = dir_rd_q ? rd_short : wr_full;
    end

    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        dir_rd_d = dir_rd_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    dir_rd_d = rd_rise;
                    if (!nowait_i) begin
                        state_d = ST_FIXED;
                        cnt_d   = CNT_LOAD;
                    end else if (is_data_i && need_now) begin
                        state_d = ST_FIFO;
                    end else begin
                        state_d = ST_DONE;
                    end
                end
            end
            ST_FIXED: begin
                if (cnt_q == '0) state_d = ST_DONE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            ST_FIFO: begin
                if (!strobe_on)      state_d = ST_IDLE;
                else if (!need_held) state_d = ST_DONE;
            end
            ST_DONE: begin
                if (!strobe_on) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            dir_rd_q  <= 1'b0;
            rd_prev_q <= 1'b0;
            wr_prev_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            cnt_q     <= cnt_d;
            dir_rd_q  <= dir_rd_d;
            rd_prev_q <= rd_s_i;
            wr_prev_q <= wr_s_i;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_FIXED, ST_FIFO: rdy_pull_o = 1'b1;
            default:           rdy_pull_o = 1'b0;
        endcase
    end

    assert_no_start_without_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !rd_s_i && !wr_s_i) |=> !rdy_pull_o);

    assert_fixed_count_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIXED) |-> (cnt_q <= CNT_LOAD));

    assert_fifo_read_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIFO && dir_rd_q && strobe_on && rd_fill_i >= RD_MIN) |=> !rdy_pull_o);

    assert_fifo_write_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIFO && !dir_rd_q && strobe_on && wr_fill_i <= WR_MAX) |=> !rdy_pull_o);

    assert_single_wait_per_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && strobe_on) |=> (state_q == ST_DONE && !rdy_pull_o));

    assert_aen_blocks_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && aen_s_i) |=> !rdy_pull_o);

    assert_reset_released_R11: assert property (@(posedge clk)
        $rose(rst_n) |-> !rdy_pull_o);
endmodule

// File: rtl/iodec_ready_top.sv
module iodec_ready_top #(
    parameter int WAIT_CYCLES = 30,
    parameter int FILL_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       addr_i,
    input  logic              aen_i,
    input  logic              ior_n_i,
    input  logic              iow_n_i,
    input  logic              bus16_i,
    input  logic [11:0]       io_base_i,
    input  logic              nowait_i,
    input  logic [FILL_W-1:0] rd_fill_i,
    input  logic [FILL_W-1:0] wr_fill_i,
    output logic              cs16_n_o,
    output logic              rdy_pull_o
);
    localparam int ADDR_W = 16;
    localparam int BLK_W  = 4;

    logic [2:0] raw_ctl, sync_ctl;
    logic       hit, is_data;

    assign raw_ctl = {aen_i, !ior_n_i, !iow_n_i};

    iodec_sync #(.WIDTH(3), .RST_VAL(3'b100)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_ctl),
        .sync_o  (sync_ctl)
    );

    iodec_addr_match #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .DATA_OFS(4'h8)) u_match (
        .addr_i    (addr_i),
        .aen_i     (aen_i),
        .base_i    (io_base_i),
        .bus16_i   (bus16_i),
        .hit_o     (hit),
        .is_data_o (is_data),
        .cs16_n_o  (cs16_n_o)
    );

    iodec_ready_fsm #(.WAIT_CYCLES(WAIT_CYCLES), .FILL_W(FILL_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_s_i     (sync_ctl[1]),
        .wr_s_i     (sync_ctl[0]),
        .aen_s_i    (sync_ctl[2]),
        .hit_i      (hit),
        .is_data_i  (is_data),
        .nowait_i   (nowait_i),
        .rd_fill_i  (rd_fill_i),
        .wr_fill_i  (wr_fill_i),
        .rdy_pull_o (rdy_pull_o)
    );

    always_comb begin
        if (rst_n) begin
            assert_cs16_needs_bus16_R2: assert (bus16_i || cs16_n_o);
            assert_cs16_blocked_by_aen_R1: assert (!aen_i || cs16_n_o);
        end
    end
endmodule

// File: tb/iodec_ready_top_tb.sv
module iodec_ready_top_tb;
    localparam int WAITC = 30;
    localparam int FW    = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   addr = 16'h0000;
    logic          aen = 1'b1;
    logic          ior_n = 1'b1;
    logic          iow_n = 1'b1;
    logic          bus16 = 1'b0;
    logic [11:0]   base = 12'h030;
    logic          nowait = 1'b0;
    logic [FW-1:0] rd_fill = '0;
    logic [FW-1:0] wr_fill = '0;
    logic          cs16_n, rdy_pull;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    iodec_ready_top #(.WAIT_CYCLES(WAITC), .FILL_W(FW)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .aen_i(aen),
        .ior_n_i(ior_n), .iow_n_i(iow_n), .bus16_i(bus16), .io_base_i(base),
        .nowait_i(nowait), .rd_fill_i(rd_fill), .wr_fill_i(wr_fill),
        .cs16_n_o(cs16_n), .rdy_pull_o(rdy_pull)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: sample history queues and a phase integer
    bit rq[$], wq[$], aq[$];
    int ph  = 0;   // 0 idle, 1 fixed wait, 2 fifo wait, 3 done
    int rem = 0;
    bit mrd = 0;

    function automatic bit short_fifo(bit is_rd);
        return is_rd ? (rd_fill < 2) : (wr_fill > 2);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            rq = '{0, 0, 0}; wq = '{0, 0, 0}; aq = '{1, 1, 1};
            ph = 0; rem = 0; mrd = 0;
        end else begin
            bit rs, rp, ws, wp, as_, hit, dat, any;
            rs = rq[1]; rp = rq[0]; ws = wq[1]; wp = wq[0]; as_ = aq[1];
            hit = !aen && (addr[15:4] == base);
            dat = (addr[3:1] == 3'b100);
            any = rs || ws;
            case (ph)
                0: if (((rs && !rp) || (ws && !wp)) && !as_ && hit) begin
                       mrd = rs && !rp;
                       if (!nowait) begin ph = 1; rem = WAITC; end
                       else if (dat && short_fifo(mrd)) ph = 2;
                       else ph = 3;
                   end
                1: begin rem--; if (rem == 0) ph = 3; end
                2: if (!any) ph = 0; else if (!short_fifo(mrd)) ph = 3;
                default: if (!any) ph = 0;
            endcase
            rq.push_back(!ior_n); void'(rq.pop_front());
            wq.push_back(!iow_n); void'(wq.pop_front());
            aq.push_back(aen);    void'(aq.pop_front());
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            bit ecs;
            ecs = !(!aen && addr[15:4] == base && bus16);
            check(cs16_n == ecs, bus16 ? "R1" : "R2", cs16_n, ecs);
            check(rdy_pull == (ph == 1 || ph == 2), nowait ? "R6/R7/R8" : "R5",
                  rdy_pull, (ph == 1 || ph == 2));
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    // Counts cycles of rdy_pull from the third negedge after the strobe
    task automatic strobe_and_measure(input bit is_rd, output int len);
        if (is_rd) ior_n = 1'b0; else iow_n = 1'b0;
        tick(2);
        check(rdy_pull == 1'b0, "R4", rdy_pull, 0);
        tick(1);
        len = 0;
        while (rdy_pull && len < 200) begin len++; tick(1); end
    endtask

    task automatic release_all();
        ior_n = 1'b1; iow_n = 1'b1; tick(5);
    endtask

    task automatic no_pull_window(input bit is_rd, input string req);
        int seen = 0;
        if (is_rd) ior_n = 1'b0; else iow_n = 1'b0;
        for (int i = 0; i < 10; i++) begin tick(1); seen += rdy_pull; end
        check(seen == 0, req, seen, 0);
        release_all();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int len;
        tick(3);
        check(rdy_pull == 1'b0, "R11", rdy_pull, 0);
        rst_n = 1'b1;
        tick(2);
        check(rdy_pull == 1'b0, "R11", rdy_pull, 0);

        // Decode
        addr = 16'h0302; aen = 1'b0; bus16 = 1'b1; tick(1);
        check(cs16_n == 1'b0, "R1", cs16_n, 0);
        aen = 1'b1; tick(1);
        check(cs16_n == 1'b1, "R1", cs16_n, 1);
        aen = 1'b0; addr = 16'h0312; tick(1);
        check(cs16_n == 1'b1, "R1", cs16_n, 1);
        addr = 16'h0302; bus16 = 1'b0; tick(1);
        check(cs16_n == 1'b1, "R2", cs16_n, 1);
        bus16 = 1'b1; tick(8);
        check(rdy_pull == 1'b0, "R3", rdy_pull, 0);
        addr = 16'h0402; tick(3);
        no_pull_window(1'b1, "R3");
        addr = 16'h0302; tick(3);

        // Fixed mode
        nowait = 1'b0;
        strobe_and_measure(1'b1, len);
        check(len == WAITC, "R5", len, WAITC);
        tick(5);
        check(rdy_pull == 1'b0, "R9", rdy_pull, 0);
        release_all();
        addr = 16'h0308; tick(3);
        strobe_and_measure(1'b0, len);
        check(len == WAITC, "R5", len, WAITC);
        release_all();

        // FIFO-driven read
        nowait = 1'b1; rd_fill = 4'd1; tick(3);
        ior_n = 1'b0; tick(3);
        check(rdy_pull == 1'b1, "R6", rdy_pull, 1);
        tick(5);
        check(rdy_pull == 1'b1, "R6", rdy_pull, 1);
        rd_fill = 4'd2; tick(1);
        check(rdy_pull == 1'b0, "R6", rdy_pull, 0);
        tick(4);
        check(rdy_pull == 1'b0, "R9", rdy_pull, 0);
        release_all();

        // FIFO-driven write
        wr_fill = 4'd3; tick(3);
        iow_n = 1'b0; tick(3);
        check(rdy_pull == 1'b1, "R7", rdy_pull, 1);
        tick(6);
        wr_fill = 4'd2; tick(1);
        check(rdy_pull == 1'b0, "R7", rdy_pull, 0);
        release_all();

        // No wait needed
        rd_fill = 4'd2; wr_fill = 4'd2; tick(3);
        no_pull_window(1'b1, "R8");
        no_pull_window(1'b0, "R8");
        rd_fill = 4'd0; wr_fill = 4'd5; addr = 16'h0304; tick(3);
        no_pull_window(1'b1, "R8");
        no_pull_window(1'b0, "R8");

        // Read aborted while waiting on the FIFO
        addr = 16'h0309; tick(3);
        ior_n = 1'b0; tick(4);
        check(rdy_pull == 1'b1, "R6", rdy_pull, 1);
        release_all();
        check(rdy_pull == 1'b0, "R6", rdy_pull, 0);

        // AEN high blocks the cycle
        nowait = 1'b0; aen = 1'b1; tick(4);
        no_pull_window(1'b1, "R10");
        aen = 1'b0; tick(4);

        tick(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule